// File: doc/BRIEF.md
# Banked Inter-Core Interrupt Register Block

This block holds one small register set for each processor core of a multi-core cluster and drives one level interrupt line per core. A shared 32-bit register port carries a requester number with every access. That number selects which core's set is read or written, so each core sees "its own" status, enable, raise and lower ports and eight mailbox words at the same offsets.

A core raises interrupt causes in its own status word through the raise port and retires them through the lower port. A dedicated doorbell register lets any core post a numbered cause into another core's status word. The doorbell write names the target core and the cause bit in its data. Writes that name a core that does not exist, and writes to the read-only status word, come back with an error response.

Responses arrive one cycle after the request. Status, enable, mailboxes and interrupt lines all reset to zero. The interrupt line is asserted on a raise when pending-and-enabled causes exist. It is released on a lower only when the status becomes empty while enable is nonzero.

Top module: `ipi_bank_top`

## Requirements
- R1: After reset every core's status, enable and mailbox words read zero and every interrupt line is low.
- R2: A write to the enable word (offset 0x04) stores the data in the requester's set and reads back unchanged; it never changes an interrupt line.
- R3: A write to the raise port (offset 0x08) ORs the data into the requester's status; the interrupt line goes high on the next clock edge when the new status ANDed with enable is nonzero.
- R4: A raise whose resulting status has no bit in common with enable leaves the interrupt line as it was.
- R5: A write to the lower port (offset 0x0C) clears the status bits that are one in the data; the line goes low only if the resulting status is zero and enable is nonzero, otherwise it keeps its level.
- R6: The status word (offset 0x00) is read-only: a write leaves it unchanged and its response carries the error flag.
- R7: Reads of the raise and lower ports return zero, and no read changes any state.
- R8: Eight mailbox words sit at offsets 0x20 to 0x3C, word index (offset - 0x20) / 4; each is written and read back as 32 bits.
- R9: Every access touches only the set of the core named by the requester number; the other cores' registers are unchanged.
- R10: A write to the doorbell (offset 0x40) takes the target core from data bits [25:16] and the cause number from bits [4:0], and acts as a raise of (1 << cause) on the target's set, with the same one-cycle latency as a direct raise and no error.
- R11: A doorbell write naming a target at or above the core count returns the error flag and changes no register and no interrupt line.
- R12: Only address bits [7:0] are decoded; reads of unmapped offsets return zero without error, and every request gets exactly one response one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_id | input | ID_W | Requester core number selecting the register set |
| req_addr | input | ADDR_W | Byte address; bits [7:0] decoded |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | 32 | Read data (zero for writes and unmapped reads) |
| rsp_err | output | 1 | Error flag for the response |
| irq_o | output | NUM_CORES | Registered interrupt level per core |

## Verification
The checker takes for granted that each request lasts a single cycle, that the requester number is below the core count, and that addresses are word aligned, so that every change of an interrupt line can be traced to one raise, lower or doorbell write in the cycle before. The directed tasks keep to this: each drives one access for one clock and then idles, uses only requester numbers of existing cores, and places deliberately bad values only in the doorbell target field and the upper address bits.

// File: rtl/ipi_bank_pkg.sv
package ipi_bank_pkg;

   localparam int unsigned WORD_W      = 32;
   localparam int unsigned OFFS_W      = 8;
   localparam int unsigned MBOX_WORDS  = 8;
   localparam int unsigned MBOX_IDX_W  = $clog2(MBOX_WORDS);
   localparam int unsigned TGT_W       = 10;
   localparam int unsigned VEC_W       = 5;

   localparam logic [OFFS_W-1:0] OFF_STATUS  = 8'h00;
   localparam logic [OFFS_W-1:0] OFF_ENABLE  = 8'h04;
   localparam logic [OFFS_W-1:0] OFF_RAISE   = 8'h08;
   localparam logic [OFFS_W-1:0] OFF_LOWER   = 8'h0C;
   localparam logic [OFFS_W-1:0] OFF_MBOX_LO = 8'h20;
   localparam logic [OFFS_W-1:0] OFF_MBOX_HI = 8'h3C;
   localparam logic [OFFS_W-1:0] OFF_DOORBELL = 8'h40;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_STATUS,
      OP_ENABLE,
      OP_RAISE,
      OP_LOWER,
      OP_MBOX,
      OP_DOORBELL
   } reg_op_e;

   typedef struct packed {
      reg_op_e                op;
      logic [MBOX_IDX_W-1:0]  mbox_idx;
   } reg_sel_t;

endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
   import ipi_bank_pkg::*;
(
   input  logic [OFFS_W-1:0] offs,
   output reg_sel_t          sel
);

   logic [OFFS_W-1:0] mbox_rel;

   always_comb begin
      mbox_rel     = offs - OFF_MBOX_LO;
      sel.op       = OP_NONE;
      sel.mbox_idx = mbox_rel[MBOX_IDX_W+1:2];
      if (offs[1:0] == 2'b00) begin
         if (offs == OFF_STATUS)        sel.op = OP_STATUS;
         else if (offs == OFF_ENABLE)   sel.op = OP_ENABLE;
         else if (offs == OFF_RAISE)    sel.op = OP_RAISE;
         else if (offs == OFF_LOWER)    sel.op = OP_LOWER;
         else if (offs == OFF_DOORBELL) sel.op = OP_DOORBELL;
         else if (offs >= OFF_MBOX_LO && offs <= OFF_MBOX_HI) sel.op = OP_MBOX;
      end
   end

endmodule

// File: rtl/ipi_send_route.sv
module ipi_send_route
   import ipi_bank_pkg::*;
#(
   parameter int unsigned NUM_CORES = 4
)(
   input  logic [TGT_W-1:0]  tgt_field,
   input  logic [VEC_W-1:0]  vec_field,
   output logic              tgt_ok,
   output logic [WORD_W-1:0] vec_bits
);

   always_comb begin
      tgt_ok   = (32'(tgt_field) < NUM_CORES);
      vec_bits = WORD_W'(1) << vec_field;
   end

endmodule

// File: rtl/ipi_core_bank.sv
module ipi_core_bank
   import ipi_bank_pkg::*;
(
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              en_we,
   input  logic                              raise_req,
   input  logic [WORD_W-1:0]                 raise_bits,
   input  logic                              lower_req,
   input  logic                              mbox_we,
   input  logic [MBOX_IDX_W-1:0]             mbox_idx,
   input  logic [WORD_W-1:0]                 wdata,
   output logic [WORD_W-1:0]                 status_q,
   output logic [WORD_W-1:0]                 enable_q,
   output logic [MBOX_WORDS-1:0][WORD_W-1:0] mbox_q,
   output logic                              irq_q
);

   logic [WORD_W-1:0] status_nx;
   logic              assert_c;
   logic              release_c;

   always_comb begin
      status_nx = status_q;
      if (raise_req) status_nx = status_nx | raise_bits;
      if (lower_req) status_nx = status_nx & ~wdata;
      assert_c  = raise_req && (status_nx != '0) && ((status_nx & enable_q) != '0);
      release_c = lower_req && (status_nx == '0) && (enable_q != '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= '0;
         enable_q <= '0;
         mbox_q   <= '0;
         irq_q    <= 1'b0;
      end else begin
         status_q <= status_nx;
         if (en_we)   enable_q <= wdata;
         if (mbox_we) mbox_q[mbox_idx] <= wdata;
         if (assert_c)       irq_q <= 1'b1;
         else if (release_c) irq_q <= 1'b0;
      end
   end

endmodule

// File: rtl/ipi_bank_top.sv
module ipi_bank_top
   import ipi_bank_pkg::*;
#(
   parameter int unsigned NUM_CORES = 4,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned ID_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [ID_W-1:0]      req_id,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [WORD_W-1:0]    req_wdata,
   output logic                 rsp_valid,
   output logic [WORD_W-1:0]    rsp_rdata,
   output logic                 rsp_err,
   output logic [NUM_CORES-1:0] irq_o
);

   localparam int unsigned ID_MIN_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

   generate
      if (NUM_CORES < 1 || NUM_CORES > (1 << TGT_W)) begin : g_bad_cores
         $error("NUM_CORES must lie between 1 and 1024");
      end
      if (ADDR_W < OFFS_W) begin : g_bad_addr
         $error("ADDR_W must cover the 8-bit register offset");
      end
      if (ID_W < ID_MIN_W) begin : g_bad_id
         $error("ID_W too narrow for NUM_CORES");
      end
   endgenerate

   reg_sel_t           sel;
   logic               wr_c;
   logic               rd_c;
   logic               id_ok;
   logic               tgt_ok;
   logic [WORD_W-1:0]  vec_bits;
   logic [TGT_W-1:0]   tgt_field;
   logic               unused_addr_hi;
   logic [WORD_W-1:0]  rdata_c;
   logic               err_c;

   logic [NUM_CORES-1:0][WORD_W-1:0]                 status_all;
   logic [NUM_CORES-1:0][WORD_W-1:0]                 enable_all;
   logic [NUM_CORES-1:0][MBOX_WORDS-1:0][WORD_W-1:0] mbox_all;

   assign unused_addr_hi = ^req_addr;
   assign tgt_field      = req_wdata[16 +: TGT_W];
   assign wr_c           = req_valid && req_write;
   assign rd_c           = req_valid && !req_write;
   assign id_ok          = (32'(req_id) < NUM_CORES);

   ipi_addr_decode u_dec (
      .offs (req_addr[OFFS_W-1:0]),
      .sel  (sel)
   );

   ipi_send_route #(.NUM_CORES(NUM_CORES)) u_route (
      .tgt_field (tgt_field),
      .vec_field (req_wdata[VEC_W-1:0]),
      .tgt_ok    (tgt_ok),
      .vec_bits  (vec_bits)
   );

   // Direct raise from the requester and doorbell raise into a target are
   // merged per core, so both land on the same clock edge.
   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      logic              own_c;
      logic              ring_c;
      logic              direct_raise_c;
      logic [WORD_W-1:0] raise_bits_c;

      assign own_c          = wr_c && id_ok && (req_id == ID_W'(c));
      assign direct_raise_c = own_c && (sel.op == OP_RAISE);
      assign ring_c         = wr_c && (sel.op == OP_DOORBELL) && tgt_ok &&
                              (tgt_field == TGT_W'(c));
      assign raise_bits_c   = (direct_raise_c ? req_wdata : '0) |
                              (ring_c ? vec_bits : '0);

      ipi_core_bank u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .en_we      (own_c && (sel.op == OP_ENABLE)),
         .raise_req  (direct_raise_c || ring_c),
         .raise_bits (raise_bits_c),
         .lower_req  (own_c && (sel.op == OP_LOWER)),
         .mbox_we    (own_c && (sel.op == OP_MBOX)),
         .mbox_idx   (sel.mbox_idx),
         .wdata      (req_wdata),
         .status_q   (status_all[c]),
         .enable_q   (enable_all[c]),
         .mbox_q     (mbox_all[c]),
         .irq_q      (irq_o[c])
      );
   end

   always_comb begin
      rdata_c = '0;
      if (rd_c && id_ok) begin
         case (sel.op)
            OP_STATUS: rdata_c = status_all[req_id];
            OP_ENABLE: rdata_c = enable_all[req_id];
            OP_MBOX:   rdata_c = mbox_all[req_id][sel.mbox_idx];
            default:   rdata_c = '0;
         endcase
      end
      err_c = wr_c && ((sel.op == OP_STATUS) ||
                       ((sel.op == OP_DOORBELL) && !tgt_ok));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         rsp_rdata <= rdata_c;
         rsp_err   <= err_c;
      end
   end

endmodule

// File: rtl/ipi_bank_checker.sv
module ipi_bank_checker
   import ipi_bank_pkg::*;
#(
   parameter int unsigned NUM_CORES = 4,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned ID_W      = 2
)(
   input logic                             clk,
   input logic                             rst_n,
   input logic                             req_valid,
   input logic                             req_write,
   input logic [ADDR_W-1:0]                req_addr,
   input logic                             rsp_valid,
   input logic                             rsp_err,
   input logic [NUM_CORES-1:0]             irq_o,
   input logic [NUM_CORES-1:0][WORD_W-1:0] status_all,
   input logic [NUM_CORES-1:0][WORD_W-1:0] enable_all
);

   AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R12
   AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R12
   AST_READ_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> !rsp_err); // R12
   AST_STATUS_WR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr[7:0] == OFF_STATUS) |=> rsp_err); // R6
   AST_STATUS_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr[7:0] == OFF_STATUS) |=> $stable(status_all)); // R6
   AST_READ_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> ($stable(status_all) && $stable(irq_o))); // R7

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_irq_chk
      AST_IRQ_RISE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq_o[c]) |-> ((status_all[c] & enable_all[c]) != '0)); // R3
      AST_IRQ_FALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(irq_o[c]) |-> (status_all[c] == '0 && enable_all[c] != '0)); // R5
      AST_IRQ_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         !(req_valid && req_write) |=> $stable(irq_o[c])); // R2
   end

endmodule

bind ipi_bank_top ipi_bank_checker #(
   .NUM_CORES (NUM_CORES),
   .ADDR_W    (ADDR_W),
   .ID_W      (ID_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_write  (req_write),
   .req_addr   (req_addr),
   .rsp_valid  (rsp_valid),
   .rsp_err    (rsp_err),
   .irq_o      (irq_o),
   .status_all (status_all),
   .enable_all (enable_all)
);

// File: tb/ipi_bank_top_tb_top.sv
`timescale 1ns/1ps
module ipi_bank_top_tb_top;

   localparam int NC  = 4;
   localparam int AW  = 16;
   localparam int IDW = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           req_valid = 1'b0;
   logic           req_write = 1'b0;
   logic [IDW-1:0] req_id = '0;
   logic [AW-1:0]  req_addr = '0;
   logic [31:0]    req_wdata = '0;
   logic           rsp_valid;
   logic [31:0]    rsp_rdata;
   logic           rsp_err;
   logic [NC-1:0]  irq_o;

   int n_tests = 0;
   int n_fail  = 0;
   logic [31:0] rd;
   logic        er;

   always #2.5 clk = ~clk;

   ipi_bank_top #(.NUM_CORES(NC), .ADDR_W(AW), .ID_W(IDW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_id(req_id), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
      .irq_o(irq_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one access: driven at a negedge, response sampled at the following negedge
   task automatic access(input logic w, input int id, input logic [AW-1:0] a,
                         input logic [31:0] d, output logic [31:0] rdata,
                         output logic err);
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_id = IDW'(id);
      req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      rdata = rsp_rdata; err = rsp_err;
      chk("R12 response valid", 32'(rsp_valid), 32'd1);
   endtask

   task automatic t_reset();
      chk("R1 irq after reset", 32'(irq_o), 32'd0);
      access(0, 0, 16'h0000, 0, rd, er); chk("R1 status core0", rd, 0);
      access(0, 2, 16'h0004, 0, rd, er); chk("R1 enable core2", rd, 0);
      access(0, 3, 16'h003C, 0, rd, er); chk("R1 mailbox core3", rd, 0);
   endtask

   task automatic t_enable();
      access(1, 1, 16'h0004, 32'h0000_00F0, rd, er);
      chk("R2 irq unchanged by enable", 32'(irq_o), 0);
      access(0, 1, 16'h0004, 0, rd, er); chk("R2 enable readback", rd, 32'hF0);
      access(0, 0, 16'h0004, 0, rd, er); chk("R9 core0 enable untouched", rd, 0);
   endtask

   task automatic t_raise_lower();
      access(1, 1, 16'h0008, 32'h01, rd, er);
      chk("R4 no overlap keeps irq low", 32'(irq_o[1]), 0);
      access(1, 1, 16'h0008, 32'h10, rd, er);
      chk("R3 irq raised", 32'(irq_o[1]), 1);
      chk("R9 other irqs low", 32'(irq_o & 4'b1101), 0);
      access(0, 1, 16'h0000, 0, rd, er); chk("R3 status ORed", rd, 32'h11);
      access(0, 1, 16'h0008, 0, rd, er); chk("R7 raise port reads zero", rd, 0);
      access(0, 1, 16'h000C, 0, rd, er); chk("R7 lower port reads zero", rd, 0);
      access(1, 1, 16'h000C, 32'h10, rd, er);
      chk("R5 nonzero status keeps irq", 32'(irq_o[1]), 1);
      access(0, 1, 16'h0000, 0, rd, er); chk("R5 bit cleared", rd, 32'h01);
      access(1, 1, 16'h000C, 32'h01, rd, er);
      chk("R5 empty status drops irq", 32'(irq_o[1]), 0);
   endtask

   task automatic t_asym();
      access(1, 2, 16'h0004, 32'h1, rd, er);
      access(1, 2, 16'h0008, 32'h1, rd, er);
      chk("R3 core2 irq raised", 32'(irq_o[2]), 1);
      access(1, 2, 16'h0004, 32'h0, rd, er);
      chk("R2 disabling keeps irq", 32'(irq_o[2]), 1);
      access(1, 2, 16'h000C, 32'h1, rd, er);
      chk("R5 zero enable keeps irq", 32'(irq_o[2]), 1);
      access(0, 2, 16'h0000, 0, rd, er); chk("R5 status empty", rd, 0);
      access(1, 2, 16'h0004, 32'h2, rd, er);
      access(1, 2, 16'h000C, 32'h0, rd, er);
      chk("R5 enabled empty lower drops irq", 32'(irq_o[2]), 0);
   endtask

   task automatic t_status_ro();
      access(1, 0, 16'h0000, 32'hFF, rd, er);
      chk("R6 status write error", 32'(er), 1);
      access(0, 0, 16'h0000, 0, rd, er);
      chk("R6 status unchanged", rd, 0);
      chk("R12 read no error", 32'(er), 0);
   endtask

   task automatic t_mbox();
      for (int i = 0; i < 8; i++)
         access(1, 3, AW'(32'h20 + 4*i), 32'hA5000000 + 32'(i), rd, er);
      for (int i = 0; i < 8; i++) begin
         access(0, 3, AW'(32'h20 + 4*i), 0, rd, er);
         chk("R8 mailbox word", rd, 32'hA5000000 + 32'(i));
      end
      access(0, 0, 16'h002C, 0, rd, er); chk("R9 core0 mailbox untouched", rd, 0);
   endtask

   task automatic t_doorbell();
      access(1, 2, 16'h0004, 32'h8000_0000, rd, er);
      access(1, 0, 16'h0040, (32'd2 << 16) | 32'hFFE0 | 32'd31, rd, er);
      chk("R10 target irq same latency", 32'(irq_o[2]), 1);
      chk("R10 no error", 32'(er), 0);
      chk("R10 sender irq low", 32'(irq_o[0]), 0);
      access(0, 2, 16'h0000, 0, rd, er); chk("R10 target status bit31", rd, 32'h8000_0000);
      access(1, 3, 16'h0040, (32'd1 << 16) | 32'd3, rd, er);
      access(0, 1, 16'h0000, 0, rd, er); chk("R10 core1 bit3", rd, 32'h8);
   endtask

   task automatic t_bad_target();
      logic [NC-1:0] irq_before;
      irq_before = irq_o;
      access(1, 0, 16'h0040, (32'd4 << 16) | 32'd1, rd, er);
      chk("R11 target 4 error", 32'(er), 1);
      access(1, 0, 16'h0040, (32'h3FF << 16) | 32'd0, rd, er);
      chk("R11 target 1023 error", 32'(er), 1);
      chk("R11 irq unchanged", 32'(irq_o), 32'(irq_before));
      access(0, 0, 16'h0000, 0, rd, er); chk("R11 core0 status", rd, 0);
      access(0, 3, 16'h0000, 0, rd, er); chk("R11 core3 status", rd, 0);
   endtask

   task automatic t_decode();
      access(1, 3, 16'hAB04, 32'h55, rd, er);
      access(0, 3, 16'h1204, 0, rd, er); chk("R12 low byte decode", rd, 32'h55);
      access(0, 3, 16'h0010, 0, rd, er); chk("R12 unmapped reads zero", rd, 0);
      chk("R12 unmapped no error", 32'(er), 0);
      access(0, 3, 16'h0044, 0, rd, er); chk("R12 past window zero", rd, 0);
   endtask

   initial begin : watchdog
      #(5.0 * 20000);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enable();
      t_raise_lower();
      t_asym();
      t_status_ro();
      t_mbox();
      t_doorbell();
      t_bad_target();
      t_decode();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule